// File: doc/BRIEF.md
# Double-Buffered Display Configuration Registers

This block holds a set of 32-bit configuration words for a display datapath. Every word has two copies. Software writes reach only the pending copy. The live copy drives the datapath, and it changes only when the pending contents are copied across during vertical blanking. This lets software build a whole new configuration over many bus cycles without the picture ever showing a half-updated state.

A control word picks when the copy happens:

- With the manual-mode bit clear, the copy happens at every blanking pulse.
- With the manual-mode bit set, the copy happens only after software has raised the load-request bit.

The load-request bit reads back as 1 until the copy has taken place, and then it clears by itself. Software can therefore poll it before starting the next update. A commit is one write that sets both bits.

The bus side is a plain port with a write strobe, a byte address and data, and a read strobe whose data returns one cycle later. Reads of configuration words return the pending copy.

Top module: `vsr_bank_top`

## Requirements
- R1: After reset, the control word reads 0, and every pending and live configuration word is 0.
- R2: A write to configuration word k (byte address CFG_BASE + 4k, default base 0x800) changes only the pending copy. A read of that address returns the new value in the cycle after the read strobe. `active_cfg` does not change without a copy.
- R3: The control word sits at byte address 0. Bit 0 is the load request and bit 1 is manual mode; all other bits read as 0. Writing 1 to bit 0 makes bit 0 read 1 until a copy happens. It reads 0 from the cycle after the copy.
- R4: With manual mode set and no load request, a blanking pulse leaves `active_cfg` unchanged.
- R5: With manual mode clear, every blanking pulse copies all pending words to `active_cfg`. The new values are visible in the cycle after the pulse.
- R6: A single control write of 0x3 commits. At the next blanking pulse the pending words are copied and the request bit clears, while manual mode stays set.
- R7: A control write that sets the request in the same cycle as a blanking pulse causes the copy in that cycle.
- R8: When a configuration write and a copy fall in the same cycle, the live copy receives the value from before the write. The pending copy receives the written value.
- R9: Writing 0 to bit 0 of the control word does not cancel a pending request. Manual mode follows bit 1 of every control write. During a cycle that writes the control word, the copy decision uses the manual-mode value from before that write.
- R10: Writes to unaligned or unmapped addresses have no effect. Reads of unmapped or unaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read data, registered, valid the cycle after `rd_en` |
| vblank | input | 1 | One-cycle vertical blanking pulse |
| active_cfg | output | NUM_REGS*DATA_W | Live configuration words, word k at bits k*DATA_W upward |

## Verification
The bench targets four corner cases.

- A copy in the same cycle as a configuration write. A design that forwarded the write would show the new value early on the live outputs.
- A request that arrives together with the blanking pulse. A design that missed this would leave the request pending for a whole extra frame.
- A control write with bit 0 clear while a request is pending. A design that cleared the request here would skip a commit that software had already issued.
- Unmapped and unaligned addresses. A design that truncated addresses would write into a real register through such an address.

A seeded random mix of writes, mode changes and blanking pulses is then compared against a bench model after every cycle.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int CTRL_REQ_BIT = 0;
  localparam int CTRL_MAN_BIT = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_CFG  = 2'd2
  } tgt_e;
endpackage

// File: rtl/vsr_decode.sv
module vsr_decode
  import vsr_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int NUM_REGS = 8,
  parameter int CTRL_OFS = 0,
  parameter int CFG_BASE = 32'h800,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    tgt = TGT_NONE;
    idx = '0;
    if (addr == ADDR_W'(CTRL_OFS)) begin
      tgt = TGT_CTRL;
    end
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr == ADDR_W'(CFG_BASE + 4 * k)) begin
        tgt = TGT_CFG;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  logic req_bit,
  input  logic man_bit,
  input  logic vblank,
  output logic xfer,
  output logic req_q,
  output logic man_q
);
  logic req_set;

  assign req_set = wr_ctrl & req_bit;
  // Mode used for this cycle is the one held before any same-cycle write.
  assign xfer    = vblank & (~man_q | req_q | req_set);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      man_q <= 1'b0;
    end else begin
      req_q <= xfer ? 1'b0 : (req_q | req_set);
      if (wr_ctrl) man_q <= man_bit;
    end
  end

  // R3: a completed copy always leaves the request bit clear
  p_req_clear_r3: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !req_q);

  // R9: a pending request survives until a blanking pulse arrives
  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    (req_q && !vblank) |=> req_q);
endmodule

// File: rtl/vsr_store.sv
module vsr_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [FLAT_W-1:0] shadow_flat,
  output logic [FLAT_W-1:0] active_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
      end else if (wr_cfg && wr_idx == IDX_W'(k)) begin
        shadow_q <= wr_data;
      end
    end

    // Copy takes the pending value held before any same-cycle write.
    always_ff @(posedge clk) begin
      if (rst) begin
        active_q <= '0;
      end else if (xfer) begin
        active_q <= shadow_q;
      end
    end

    assign shadow_flat[k*DATA_W +: DATA_W] = shadow_q;
    assign active_flat[k*DATA_W +: DATA_W] = active_q;
  end

  // R2: live words move only on a copy
  p_live_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(active_flat));

  // R8: a copy delivers the pending words from before the edge
  p_copy_prewrite_r8: assert property (@(posedge clk) disable iff (rst)
    xfer |=> active_flat == $past(shadow_flat));
endmodule

// File: rtl/vsr_bank_top.sv
module vsr_bank_top
  import vsr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 15,
  parameter int NUM_REGS = 8,
  parameter int CTRL_OFS = 0,
  parameter int CFG_BASE = 32'h800,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vblank,
  output logic [FLAT_W-1:0] active_cfg
);
  tgt_e             wr_tgt;
  tgt_e             rd_tgt;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_ctrl;
  logic             wr_cfg;
  logic             xfer;
  logic             req_q;
  logic             man_q;
  logic [FLAT_W-1:0] shadow_flat;

  vsr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CTRL_OFS(CTRL_OFS),
               .CFG_BASE(CFG_BASE)) u_wr_dec (
    .addr(wr_addr), .tgt(wr_tgt), .idx(wr_idx));

  vsr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CTRL_OFS(CTRL_OFS),
               .CFG_BASE(CFG_BASE)) u_rd_dec (
    .addr(rd_addr), .tgt(rd_tgt), .idx(rd_idx));

  assign wr_ctrl = wr_en && (wr_tgt == TGT_CTRL);
  assign wr_cfg  = wr_en && (wr_tgt == TGT_CFG);

  vsr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl),
    .req_bit(wr_data[CTRL_REQ_BIT]), .man_bit(wr_data[CTRL_MAN_BIT]),
    .vblank(vblank), .xfer(xfer), .req_q(req_q), .man_q(man_q));

  vsr_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .xfer(xfer),
    .shadow_flat(shadow_flat), .active_flat(active_cfg));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rd_tgt)
        TGT_CTRL: rd_data <= DATA_W'({man_q, req_q});
        TGT_CFG:  rd_data <= shadow_flat[rd_idx*DATA_W +: DATA_W];
        default:  rd_data <= '0;
      endcase
    end
  end

  // R5: in automatic mode every blanking pulse refreshes the live words
  p_auto_load_r5: assert property (@(posedge clk) disable iff (rst)
    (vblank && !man_q) |=> active_cfg == $past(shadow_flat));

  // R4: manual mode without any request keeps the live words
  p_manual_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (man_q && !req_q && !(wr_ctrl && wr_data[CTRL_REQ_BIT]))
      |=> $stable(active_cfg));

  // R7: a request written together with a blanking pulse is served at once
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (vblank && wr_ctrl && wr_data[CTRL_REQ_BIT]) |=> !req_q);
endmodule

// File: tb/vsr_bank_top_tb.sv
module vsr_bank_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int AW   = 15;
  localparam int NR   = 8;
  localparam int BASE = 32'h800;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en, vblank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] active_cfg;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] m_sh  [NR];
  logic [DW-1:0] m_act [NR];
  logic          m_req, m_man;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsr_bank_top #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .CFG_BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .vblank(vblank), .active_cfg(active_cfg));

  function automatic logic [AW-1:0] cfg_addr(int k);
    return AW'(BASE + 4 * k);
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    if (a == '0) return DW'({m_man, m_req});
    for (int k = 0; k < NR; k++)
      if (a == cfg_addr(k)) return m_sh[k];
    return '0;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NR; k++) begin
      m_sh[k]  = '0;
      m_act[k] = '0;
    end
    m_req = 1'b0;
    m_man = 1'b0;
  endtask

  // One clock with an optional write and blanking pulse; model follows the requirements.
  task automatic step(input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic vb);
    logic rset, xf;
    wr_en = we; wr_addr = a; wr_data = d; vblank = vb;
    @(posedge clk);
    rset = we && (a == '0) && d[0];
    xf   = vb && (!m_man || m_req || rset);
    if (xf) for (int k = 0; k < NR; k++) m_act[k] = m_sh[k];
    if (we) begin
      for (int k = 0; k < NR; k++) if (a == cfg_addr(k)) m_sh[k] = d;
      if (a == '0) m_man = d[1];
    end
    m_req = xf ? 1'b0 : (m_req | rset);
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
  endtask

  task automatic check_active(input string tag);
    logic ok = 1'b1;
    for (int k = 0; k < NR; k++) begin
      tests++;
      if (active_cfg[k*DW +: DW] !== m_act[k]) begin
        ok = 1'b0;
        fails++;
        $display("FAIL %s: active word %0d = %h, expected %h",
                 tag, k, active_cfg[k*DW +: DW], m_act[k]);
      end
    end
  endtask

  task automatic check_read(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e;
    e = exp_read(a);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    tests++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s: read at %h = %h, expected %h", tag, a, rd_data, e);
    end
  endtask

  task automatic check_val(input logic [DW-1:0] act, input logic [DW-1:0] e,
                           input string tag);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", tag, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    wr_en = 0; rd_en = 0; vblank = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    rst = 1'b1;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check_active("R1");
    check_read('0, "R1 ctrl");
    check_read(cfg_addr(0), "R1 word0");

    // R2 then R5: automatic mode
    step(1, cfg_addr(2), 32'hA5A5_0002, 0);
    check_active("R2 pending only");
    check_read(cfg_addr(2), "R2 readback");
    step(0, '0, '0, 1);
    check_active("R5 auto copy");
    check_val(active_cfg[2*DW +: DW], 32'hA5A5_0002, "R5 word2");

    // R4: manual mode, no request
    step(1, '0, 32'h2, 0);
    step(1, cfg_addr(3), 32'hBEEF_0003, 0);
    step(0, '0, '0, 1);
    check_active("R4 manual hold");
    check_val(active_cfg[3*DW +: DW], '0, "R4 word3");

    // R6, R3, R9: commit, then a write of bit0=0 while pending
    step(1, '0, 32'h3, 0);
    check_read('0, "R3 busy");
    step(1, '0, 32'h2, 0);
    check_read('0, "R9 not cancelled");
    check_val(rd_data, 32'h3, "R9 still busy");
    step(0, '0, '0, 1);
    check_active("R6 commit copy");
    check_val(active_cfg[3*DW +: DW], 32'hBEEF_0003, "R6 word3");
    check_read('0, "R3 cleared");
    check_val(rd_data, 32'h2, "R3 cleared value");

    // R7: request and blanking pulse in the same cycle
    step(1, cfg_addr(4), 32'h0C0C_0004, 0);
    step(1, '0, 32'h3, 1);
    check_active("R7 same cycle");
    check_read('0, "R7 request consumed");

    // R8: write and copy collide
    step(1, cfg_addr(5), 32'h0000_00E5, 0);
    step(1, '0, 32'h3, 0);
    step(1, cfg_addr(5), 32'h0000_00F5, 1);
    check_val(active_cfg[5*DW +: DW], 32'h0000_00E5, "R8 prior value");
    check_read(cfg_addr(5), "R8 pending new");

    // R10: unaligned / unmapped accesses
    step(1, AW'(BASE + 1), 32'hDEAD_DEAD, 0);
    step(1, cfg_addr(NR), 32'hDEAD_BEEF, 0);
    step(1, AW'(4), 32'hDEAD_0004, 0);
    check_read(cfg_addr(0), "R10 unaligned ignored");
    check_read(cfg_addr(NR), "R10 unmapped reads 0");
    check_read(AW'(BASE + 1), "R10 unaligned reads 0");
    check_active("R10 live unchanged");

    // Random mix against the model (R2..R9)
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      sel = $urandom_range(0, 9);
      d   = $urandom;
      if (sel < 2)      a = '0;
      else if (sel < 9) a = cfg_addr($urandom_range(0, NR-1));
      else              a = AW'($urandom_range(0, 32'h57FF));
      if (a == '0) d = DW'($urandom_range(0, 3));
      step(($urandom_range(0, 2) != 0), a, d, ($urandom_range(0, 3) == 0));
      check_active("R5/R8 random");
      if (i % 8 == 0) check_read(a, "R2/R3 random read");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule